// File: doc/BRIEF.md
# CSR multiplexer with atomic wide registers

This block sits between a narrow control/status bus and a set of registers. Some registers may be wider than the bus. Each register gets a run of consecutive bus addresses, and the runs are packed back to back in register index order. A register wider than the bus is split into bus-width chunks, with the least significant chunk at its lowest address.

Every wide register has its own shadow buffer, which makes each wide access atomic.
- **Reads:** reading the first chunk samples the whole register into the shadow buffer. Reads of the later chunks are served from that buffer, so they return the value sampled by the first-chunk read even if the register has changed since.
- **Writes:** writes to the lower chunks only fill the shadow buffer. The write to the last chunk presents the full value to the register, with a single write strobe.

A register that fits in one chunk is read and written directly.

The bus read data is registered. It appears one clock after the read access and is zero at every other time.

Top module: `csr_mux`

## Requirements
- R1: With the default chunk counts {1,2,4} on an 8-bit bus, register 0 occupies address 0, register 1 occupies addresses 1..2 and register 2 occupies addresses 3..6. An access to one register never strobes another.
- R2: Within a wide register, the chunk at base address + k carries bits [8k+7:8k].
- R3: A write to a chunk of a wide register other than its last chunk does not assert that register's write strobe and leaves the register unchanged.
- R4: A write to the last chunk asserts the write strobe for exactly one cycle. The write data is the earlier shadow chunks in the low bits and the current bus data in the top chunk.
- R5: A read of chunk 0 of a wide register asserts its read strobe once and samples the full register into the shadow buffer. The returned chunk 0 comes from that sample.
- R6: Reads of a wide register's later chunks assert no read strobe. They return the value sampled at the last chunk-0 read, even if the register has since changed.
- R7: A single-chunk register is written and read directly, with one write strobe or one read strobe per access.
- R8: `r_data_o` carries the read result in the cycle after `r_stb_i` is sampled high. It is zero in every cycle not preceded by a read, and zero after a read of an unmapped address.
- R9: Reset clears all shadow buffers. Reading a later chunk before any chunk-0 read returns zero.
- R10: At most one register read strobe, and at most one register write strobe, are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Bus chunk address |
| r_stb_i | input | 1 | Bus read access |
| w_stb_i | input | 1 | Bus write access |
| w_data_i | input | BUS_W | Bus write data |
| r_data_o | output | BUS_W | Bus read data, one cycle after the read |
| reg_r_data_i | input | NREG x MAX_W | Current value of each register |
| reg_r_stb_o | output | NREG | Per-register read strobe |
| reg_w_stb_o | output | NREG | Per-register write strobe |
| reg_w_data_o | output | NREG x MAX_W | Per-register full write value |

## Verification
The hardest case to reach from the ports is a register that changes between the chunk-0 read and the later chunk reads. The shadow buffer must hide that change.

To reach it, the bench owns the register models. After the chunk-0 read it overwrites the 32-bit register with an unrelated value, then reads the remaining chunks and expects the old bytes. It then reads chunk 0 again and expects the new value.

Two further cases get the same treatment:
- A later-chunk read straight after reset, which exposes the cleared shadow.
- A partial write interrupted by an access to another register, which must not lose the buffered low chunk.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;
  function automatic int unsigned clog2_1(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/csr_mux_dec.sv
module csr_mux_dec #(
  parameter int unsigned AW     = 4,
  parameter int unsigned NREG   = 3,
  parameter int unsigned CW     = 2,
  parameter int unsigned CHUNKS [NREG] = '{1, 2, 4}
) (
  input  logic [AW-1:0]             addr_i,
  output logic [NREG-1:0]           sel_o,
  output logic [NREG-1:0][CW-1:0]   chunk_o
);
  function automatic int unsigned base_of(input int unsigned idx);
    int unsigned s = 0;
    for (int unsigned j = 0; j < idx; j++) s += CHUNKS[j];
    return s;
  endfunction

  logic [AW:0] addr_x;
  assign addr_x = {1'b0, addr_i};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW:0] LO = (AW+1)'(base_of(i));
    localparam logic [AW:0] HI = (AW+1)'(base_of(i) + CHUNKS[i]);
    logic [AW:0] offs;
    assign offs       = addr_x - LO;
    assign sel_o[i]   = (addr_x >= LO) && (addr_x < HI);
    assign chunk_o[i] = offs[CW-1:0];
  end
endmodule

// File: rtl/csr_mux_slot.sv
module csr_mux_slot #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned C     = 2,
  parameter int unsigned MAX_W = 32,
  parameter int unsigned CW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [CW-1:0]     chunk_i,
  input  logic              r_stb_i,
  input  logic              w_stb_i,
  input  logic [BUS_W-1:0]  w_data_i,
  input  logic [MAX_W-1:0]  reg_r_data_i,
  output logic              reg_r_stb_o,
  output logic              reg_w_stb_o,
  output logic [MAX_W-1:0]  reg_w_data_o,
  output logic [BUS_W-1:0]  rd_chunk_o
);
  localparam int unsigned W = C * BUS_W;

  logic rd_hit, wr_hit;
  assign rd_hit = sel_i & r_stb_i;
  assign wr_hit = sel_i & w_stb_i;

  if (C == 1) begin : g_narrow
    logic unused_ok;
    assign unused_ok    = ^{clk_i, rst_ni, chunk_i, reg_r_data_i};
    assign reg_r_stb_o  = rd_hit;
    assign reg_w_stb_o  = wr_hit;
    assign reg_w_data_o = MAX_W'(w_data_i);
    assign rd_chunk_o   = reg_r_data_i[BUS_W-1:0];
  end else begin : g_wide
    logic [C-1:0][BUS_W-1:0] shadow_q;
    logic rd_first, wr_last;
    logic unused_ok;

    assign unused_ok = ^reg_r_data_i;
    assign rd_first  = rd_hit && (chunk_i == '0);
    assign wr_last   = wr_hit && (chunk_i == CW'(C - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
      end else if (rd_first) begin
        shadow_q <= reg_r_data_i[W-1:0];
      end else begin
        for (int unsigned k = 0; k < C - 1; k++)
          if (wr_hit && chunk_i == CW'(k)) shadow_q[k] <= w_data_i;
      end
    end

    assign reg_r_stb_o  = rd_first;
    assign reg_w_stb_o  = wr_last;
    assign reg_w_data_o = MAX_W'({w_data_i, shadow_q[C-2:0]});

    always_comb begin
      rd_chunk_o = reg_r_data_i[BUS_W-1:0];
      for (int unsigned k = 1; k < C; k++)
        if (chunk_i == CW'(k)) rd_chunk_o = shadow_q[k];
    end

    AST_CAPTURE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_first |=> shadow_q == $past(reg_r_data_i[W-1:0])); // R5
    AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_hit || wr_hit) |=> $stable(shadow_q)); // R6
    AST_WR_TOP_CHUNK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_w_stb_o |-> (reg_w_data_o[W-1:W-BUS_W] == w_data_i) && w_stb_i); // R4
  end
endmodule

// File: rtl/csr_mux.sv
module csr_mux
  import csr_mux_pkg::*;
#(
  parameter int unsigned BUS_W      = 8,
  parameter int unsigned NREG       = 3,
  parameter int unsigned AW         = 4,
  parameter int unsigned MAX_CHUNKS = 4,
  parameter int unsigned CHUNKS [NREG] = '{1, 2, 4},
  localparam int unsigned MAX_W     = MAX_CHUNKS * BUS_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [AW-1:0]               addr_i,
  input  logic                        r_stb_i,
  input  logic                        w_stb_i,
  input  logic [BUS_W-1:0]            w_data_i,
  output logic [BUS_W-1:0]            r_data_o,
  input  logic [NREG-1:0][MAX_W-1:0]  reg_r_data_i,
  output logic [NREG-1:0]             reg_r_stb_o,
  output logic [NREG-1:0]             reg_w_stb_o,
  output logic [NREG-1:0][MAX_W-1:0]  reg_w_data_o
);
  localparam int unsigned CW = clog2_1(MAX_CHUNKS);

  logic [NREG-1:0]            sel;
  logic [NREG-1:0][CW-1:0]    chunk;
  logic [NREG-1:0][BUS_W-1:0] rd_chunk;
  logic [BUS_W-1:0]           rd_mux;
  logic [BUS_W-1:0]           r_data_q;

  csr_mux_dec #(.AW(AW), .NREG(NREG), .CW(CW), .CHUNKS(CHUNKS)) u_dec (
    .addr_i  (addr_i),
    .sel_o   (sel),
    .chunk_o (chunk)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    csr_mux_slot #(.BUS_W(BUS_W), .C(CHUNKS[i]), .MAX_W(MAX_W), .CW(CW)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (sel[i]),
      .chunk_i      (chunk[i]),
      .r_stb_i      (r_stb_i),
      .w_stb_i      (w_stb_i),
      .w_data_i     (w_data_i),
      .reg_r_data_i (reg_r_data_i[i]),
      .reg_r_stb_o  (reg_r_stb_o[i]),
      .reg_w_stb_o  (reg_w_stb_o[i]),
      .reg_w_data_o (reg_w_data_o[i]),
      .rd_chunk_o   (rd_chunk[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int unsigned i = 0; i < NREG; i++)
      if (sel[i]) rd_mux = rd_mux | rd_chunk[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      r_data_q <= '0;
    else if (r_stb_i) r_data_q <= rd_mux;
    else              r_data_q <= '0;
  end

  assign r_data_o = r_data_q;

  AST_RSTB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_r_stb_o)); // R10
  AST_WSTB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_w_stb_o)); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_stb_i |=> r_data_o == '0); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_stb_i && sel == '0) |=> r_data_o == '0); // R8
  AST_WSTB_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_w_stb_o) |-> w_stb_i); // R3
  AST_RSTB_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_r_stb_o) |-> r_stb_i); // R6
endmodule

// File: tb/sim_csr_mux.sv
`timescale 1ns/1ps
module sim_csr_mux;
  localparam int NREG = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic r_stb_i = 1'b0, w_stb_i = 1'b0;
  logic [7:0] w_data_i = '0;
  logic [7:0] r_data_o;
  logic [NREG-1:0][31:0] regv;
  logic [NREG-1:0] reg_r_stb_o, reg_w_stb_o;
  logic [NREG-1:0][31:0] reg_w_data_o;

  int nchk = 0, nfail = 0, oh_fail = 0;
  int rcnt [NREG];
  int wcnt [NREG];
  logic rd_prev = 1'b0;
  logic poke_en = 1'b0;
  int poke_idx = 0;
  logic [31:0] poke_val = '0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  csr_mux u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .r_stb_i(r_stb_i),
    .w_stb_i(w_stb_i), .w_data_i(w_data_i), .r_data_o(r_data_o),
    .reg_r_data_i(regv), .reg_r_stb_o(reg_r_stb_o), .reg_w_stb_o(reg_w_stb_o),
    .reg_w_data_o(reg_w_data_o)
  );

  initial begin
    regv = '0;
    for (int i = 0; i < NREG; i++) begin rcnt[i] = 0; wcnt[i] = 0; end
  end

  // register models and strobe counters
  always @(posedge clk) begin
    rd_prev <= r_stb_i;
    if (rst_ni) begin
      if ($countones(reg_r_stb_o) > 1 || $countones(reg_w_stb_o) > 1) oh_fail++;
      for (int i = 0; i < NREG; i++) begin
        if (reg_r_stb_o[i]) rcnt[i]++;
        if (reg_w_stb_o[i]) begin
          wcnt[i]++;
          regv[i] <= reg_w_data_o[i];
        end
      end
      if (poke_en) regv[poke_idx] <= poke_val;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_prev && rst_ni) begin
      if (exp_q.size() == 0) chk("R8 unexpected read data", 32'(r_data_o), 32'hx);
      else chk(tag_q.pop_front(), 32'(r_data_o), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; w_data_i = d; w_stb_i = 1'b1; r_stb_i = 1'b0;
    @(negedge clk);
    w_stb_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr_i = a; r_stb_i = 1'b1; w_stb_i = 1'b0;
    @(negedge clk);
    r_stb_i = 1'b0;
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    poke_idx = idx; poke_val = v; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset r_data_o", 32'(r_data_o), 0);
    chk("R10 reset strobes", 32'({reg_r_stb_o, reg_w_stb_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: cleared shadow, no strobe on later chunk
    rd(4'd4, 8'h00, "R9 shadow after reset");
    rd(4'd6, 8'h00, "R9 shadow after reset top");
    chk("R6 no rstb on later chunk", 32'(rcnt[2]), 0);

    // R7: single-chunk register
    wr(4'd0, 8'h55);
    chk("R7 reg0 written", regv[0], 32'h55);
    chk("R7 reg0 one wstb", 32'(wcnt[0]), 1);
    chk("R1 no wstb on others", 32'(wcnt[1] + wcnt[2]), 0);
    rd(4'd0, 8'h55, "R7 reg0 read");
    chk("R7 reg0 one rstb", 32'(rcnt[0]), 1);

    // R3/R4: 16-bit register
    wr(4'd1, 8'haa);
    chk("R3 no wstb low chunk", 32'(wcnt[1]), 0);
    chk("R3 reg1 unchanged", regv[1], 0);
    wr(4'd2, 8'hbb);
    chk("R4 one wstb last chunk", 32'(wcnt[1]), 1);
    chk("R4 R1 reg1 full value", regv[1], 32'hbbaa);

    // R2/R5/R6: chunk order on read
    rd(4'd1, 8'haa, "R2 R5 reg1 chunk0");
    rd(4'd2, 8'hbb, "R2 R6 reg1 chunk1");
    chk("R5 reg1 one rstb", 32'(rcnt[1]), 1);

    // R3: interrupted partial write keeps shadow
    wr(4'd1, 8'h12);
    wr(4'd0, 8'h77);
    chk("R3 reg1 untouched mid write", regv[1], 32'hbbaa);
    wr(4'd2, 8'h34);
    chk("R4 reg1 after interrupt", regv[1], 32'h3412);

    // 32-bit register write
    wr(4'd3, 8'h11);
    wr(4'd4, 8'h22);
    wr(4'd5, 8'h33);
    chk("R3 reg2 no wstb yet", 32'(wcnt[2]), 0);
    chk("R3 reg2 unchanged", regv[2], 0);
    wr(4'd6, 8'h44);
    chk("R4 reg2 value", regv[2], 32'h44332211);
    chk("R4 reg2 one wstb", 32'(wcnt[2]), 1);

    // R6: register changes after chunk-0 read
    rd(4'd3, 8'h11, "R5 reg2 chunk0");
    poke(2, 32'hdeadbeef);
    rd(4'd4, 8'h22, "R6 stale chunk1");
    rd(4'd5, 8'h33, "R6 stale chunk2");
    rd(4'd6, 8'h44, "R6 stale chunk3");
    chk("R6 reg2 one rstb", 32'(rcnt[2]), 1);
    rd(4'd3, 8'hef, "R5 recapture chunk0");
    rd(4'd6, 8'hde, "R2 recapture chunk3");
    chk("R5 reg2 second rstb", 32'(rcnt[2]), 2);

    // R8: unmapped and idle
    rd(4'd7, 8'h00, "R8 unmapped 7");
    rd(4'd15, 8'h00, "R8 unmapped 15");
    chk("R8 unmapped no strobes", 32'(rcnt[0] + rcnt[1] + rcnt[2]), 4);
    @(negedge clk);
    chk("R8 idle zero", 32'(r_data_o), 0);

    repeat (3) @(negedge clk);
    chk("R10 strobe onehot", 32'(oh_fail), 0);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule